// File: doc/BRIEF.md
# Prefix-Extended Immediate Operand Former

This block is the decode slice of a small load/store RISC pipeline that turns each accepted 32-bit instruction word into register indices and a 32-bit immediate operand. Instructions come in two formats. The register-register format names two source registers. The register-immediate format carries a 16-bit constant in the low half of the word. A single opcode bit tells the two apart.

Without help, a 16-bit constant is sign-extended to 32 bits. A dedicated prefix instruction can supply the upper 16 bits instead. The block remembers that half for exactly one following accepted instruction. If that instruction is register-immediate, the two halves are joined with no sign extension. If it is anything else, the remembered half is thrown away.

A stall freezes the slice completely. A flush discards the remembered half and any instruction presented in the same cycle.

Top module: `immOperandFormer`

## Requirements
- R1: Field positions (bit 31 is the word's first bit): opcode is instr[31:26], destination index is instr[25:21], source A index is instr[20:16], source B index is instr[15:11], and the 16-bit immediate is instr[15:0]. These fields appear on the outputs.
- R2: The format flag is opcode bit 3 (instr[29]); 1 means register-immediate. A register-register instruction drives immOut to zero and typeB to 0.
- R3: A register-immediate instruction with no pending prefix produces immOut equal to instr[15:0] sign-extended from bit 15.
- R4: An instruction whose opcode equals PREFIX_OP (default 6'b101100) raises isPrefix and latches its instr[15:0] as the pending upper half.
- R5: A register-immediate instruction accepted directly after a prefix produces immOut = {latched half, instr[15:0]}, with no sign extension.
- R6: The pending half applies only to the next accepted instruction. If that instruction is register-register, the half is lost, and a later register-immediate instruction is sign-extended again.
- R7: flush clears the pending half. An instruction presented with flush is dropped, and outValid is 0 in the following cycle.
- R8: While stall is high and flush is low, all outputs and the pending half hold their values, and a prefix survives the stall.
- R9: After reset, outValid, isPrefix, typeB, the indices and immOut are all zero.
- R10: An instruction is accepted when instrValid is 1 and both stall and flush are 0. Its results appear on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| stall | input | 1 | Hold the stage |
| flush | input | 1 | Drop pending prefix and current word |
| outValid | output | 1 | Outputs describe an accepted instruction |
| rdIdx | output | 5 | Destination register index |
| raIdx | output | 5 | Source A register index |
| rbIdx | output | 5 | Source B register index |
| typeB | output | 1 | Register-immediate format |
| immOut | output | 32 | Final 32-bit immediate operand |
| isPrefix | output | 1 | Instruction is the prefix |

## Verification
Every result is due one rising edge after the instruction is accepted. The pending half affects the instruction accepted at the edge after the prefix, and no edge after that. The bench drives each word on a falling edge and waits for the next rising edge. It samples 2 ns later, so each check sees the state left by exactly one edge. Stall and flush cases are checked in the cycle the held or cleared state should appear. The following instruction then shows whether the pending half survived.

// File: rtl/immfmt_pkg.sv
package immfmt_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int IMM_W   = 16;

  typedef struct packed {
    logic accept;     // word taken this cycle
    logic loadUpper;  // latch the prefix half
    logic selTypeB;   // register-immediate format
    logic usePrefix;  // join the pending half
    logic prefixOp;   // word is the prefix
  } ctrlStrobes_t;
endpackage

// File: rtl/immPrefixCtrl.sv
module immPrefixCtrl
  import immfmt_pkg::*;
#(
  parameter logic [OP_W-1:0] PREFIX_OP   = 6'b101100,
  parameter int              TYPE_B_BIT  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [OP_W-1:0]    opcode,
  input  logic               stall,
  input  logic               flush,
  output ctrlStrobes_t       strobes,
  output logic               outValid
);
  logic prefixValid;
  logic isTypeB;
  logic isPre;

  assign isTypeB = opcode[TYPE_B_BIT];
  assign isPre   = (opcode == PREFIX_OP);

  always_comb begin
    strobes.accept    = instrValid && !stall && !flush;
    strobes.prefixOp  = isPre;
    strobes.selTypeB  = isTypeB;
    strobes.loadUpper = strobes.accept && isPre;
    strobes.usePrefix = prefixValid && isTypeB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefixValid <= 1'b0;
      outValid    <= 1'b0;
    end else if (flush) begin
      prefixValid <= 1'b0;
      outValid    <= 1'b0;
    end else if (!stall) begin
      outValid <= instrValid;
      if (instrValid) prefixValid <= isPre;
    end
  end

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (!prefixValid && !outValid));
  p_stall_holds_prefix_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stall && !flush) |=> ($stable(prefixValid) && $stable(outValid)));
  p_prefix_single_use_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && !isPre) |=> !prefixValid);
  p_prefix_armed_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadUpper |=> prefixValid);
endmodule

// File: rtl/immDatapath.sv
module immDatapath
  import immfmt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [INSTR_W-1:0] instr,
  output logic [REG_W-1:0]   rdIdx,
  output logic [REG_W-1:0]   raIdx,
  output logic [REG_W-1:0]   rbIdx,
  output logic               typeB,
  output logic [INSTR_W-1:0] immOut,
  output logic               isPrefix
);
  localparam int EXT_W = INSTR_W - IMM_W;

  logic [IMM_W-1:0]   upperQ;
  logic [IMM_W-1:0]   lowHalf;
  logic [INSTR_W-1:0] immNext;

  assign lowHalf = instr[IMM_W-1:0];

  always_comb begin
    if (!strobes.selTypeB)
      immNext = '0;
    else if (strobes.usePrefix)
      immNext = {upperQ, lowHalf};
    else
      immNext = {{EXT_W{lowHalf[IMM_W-1]}}, lowHalf};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ   <= '0;
      rdIdx    <= '0;
      raIdx    <= '0;
      rbIdx    <= '0;
      typeB    <= 1'b0;
      immOut   <= '0;
      isPrefix <= 1'b0;
    end else if (strobes.accept) begin
      if (strobes.loadUpper) upperQ <= lowHalf;
      rdIdx    <= instr[INSTR_W-OP_W-1 -: REG_W];
      raIdx    <= instr[INSTR_W-OP_W-REG_W-1 -: REG_W];
      rbIdx    <= instr[IMM_W-1 -: REG_W];
      typeB    <= strobes.selTypeB;
      immOut   <= immNext;
      isPrefix <= strobes.prefixOp;
    end
  end

  p_join_after_prefix_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && strobes.usePrefix) |=>
      (immOut == {$past(upperQ), $past(lowHalf)}));
  p_sign_extend_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && strobes.selTypeB && !strobes.usePrefix) |=>
      (immOut[INSTR_W-1:IMM_W] == {EXT_W{immOut[IMM_W-1]}}));
  p_type_a_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accept && !strobes.selTypeB) |=> (immOut == '0 && !typeB));
  p_hold_outputs_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accept |=> ($stable(immOut) && $stable(upperQ) && $stable(rdIdx)));
endmodule

// File: rtl/immOperandFormer.sv
module immOperandFormer
  import immfmt_pkg::*;
#(
  parameter logic [5:0] PREFIX_OP  = 6'b101100,
  parameter int         TYPE_B_BIT = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [31:0] instr,
  input  logic        stall,
  input  logic        flush,
  output logic        outValid,
  output logic [4:0]  rdIdx,
  output logic [4:0]  raIdx,
  output logic [4:0]  rbIdx,
  output logic        typeB,
  output logic [31:0] immOut,
  output logic        isPrefix
);
  ctrlStrobes_t strobes;

  immPrefixCtrl #(.PREFIX_OP(PREFIX_OP), .TYPE_B_BIT(TYPE_B_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .opcode(instr[INSTR_W-1 -: OP_W]), .stall(stall), .flush(flush),
    .strobes(strobes), .outValid(outValid)
  );

  immDatapath uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .instr(instr),
    .rdIdx(rdIdx), .raIdx(raIdx), .rbIdx(rbIdx), .typeB(typeB),
    .immOut(immOut), .isPrefix(isPrefix)
  );

  p_accept_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !stall && !flush) |=> outValid);
endmodule

// File: tb/immOperandFormer_test.sv
`timescale 1ns/1ps
module immOperandFormer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic        stall = 1'b0;
  logic        flush = 1'b0;
  logic        outValid, typeB, isPrefix;
  logic [4:0]  rdIdx, raIdx, rbIdx;
  logic [31:0] immOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [5:0] OP_PRE  = 6'b101100;
  localparam logic [5:0] OP_IMMB = 6'b001000;
  localparam logic [5:0] OP_REGA = 6'b000000;

  always #4 clk = ~clk;

  immOperandFormer uut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instr(instr),
    .stall(stall), .flush(flush), .outValid(outValid), .rdIdx(rdIdx),
    .raIdx(raIdx), .rbIdx(rbIdx), .typeB(typeB), .immOut(immOut),
    .isPrefix(isPrefix)
  );

  function automatic logic [31:0] mk(logic [5:0] op, logic [4:0] rd,
                                     logic [4:0] ra, logic [15:0] low);
    return {op, rd, ra, low};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic [31:0] w, logic s, logic f);
    @(negedge clk);
    instrValid = v; instr = w; stall = s; flush = f;
    @(posedge clk);
    #2;
  endtask

  task automatic testReset;  // R9
    chk("R9 outValid", {31'd0, outValid}, 32'd0);
    chk("R9 immOut", immOut, 32'd0);
    chk("R9 flags", {30'd0, typeB, isPrefix}, 32'd0);
    chk("R9 indices", {17'd0, rdIdx, raIdx, rbIdx}, 32'd0);
  endtask

  task automatic testFields;  // R1 R2 R10
    step(1, mk(OP_REGA, 5'd7, 5'd19, {5'd26, 11'h0}), 0, 0);
    chk("R10 outValid", {31'd0, outValid}, 32'd1);
    chk("R1 rdIdx", {27'd0, rdIdx}, 32'd7);
    chk("R1 raIdx", {27'd0, raIdx}, 32'd19);
    chk("R1 rbIdx", {27'd0, rbIdx}, 32'd26);
    chk("R2 typeA imm zero", immOut, 32'd0);
    chk("R2 typeA flag", {31'd0, typeB}, 32'd0);
  endtask

  task automatic testSignExt;  // R3
    step(1, mk(OP_IMMB, 5'd1, 5'd2, 16'h8004), 0, 0);
    chk("R2 typeB flag", {31'd0, typeB}, 32'd1);
    chk("R3 negative", immOut, 32'hFFFF8004);
    step(1, mk(OP_IMMB, 5'd1, 5'd2, 16'h7FFF), 0, 0);
    chk("R3 positive", immOut, 32'h00007FFF);
    step(1, mk(OP_IMMB, 5'd1, 5'd2, 16'hFFFF), 0, 0);
    chk("R3 minus one", immOut, 32'hFFFFFFFF);
  endtask

  task automatic testConcat;  // R4 R5
    step(1, mk(OP_PRE, 5'd0, 5'd0, 16'hDEAD), 0, 0);
    chk("R4 isPrefix", {31'd0, isPrefix}, 32'd1);
    step(1, mk(OP_IMMB, 5'd3, 5'd4, 16'h8EEF), 0, 0);
    chk("R5 joined", immOut, 32'hDEAD8EEF);
    chk("R4 isPrefix cleared", {31'd0, isPrefix}, 32'd0);
    step(1, mk(OP_IMMB, 5'd3, 5'd4, 16'h8EEF), 0, 0);
    chk("R6 single use", immOut, 32'hFFFF8EEF);
  endtask

  task automatic testLoss;  // R6
    step(1, mk(OP_PRE, 5'd0, 5'd0, 16'h0ABC), 0, 0);
    step(1, mk(OP_REGA, 5'd5, 5'd6, 16'h3800), 0, 0);
    chk("R6 typeA after prefix", immOut, 32'd0);
    step(1, mk(OP_IMMB, 5'd5, 5'd6, 16'hFFF0), 0, 0);
    chk("R6 half lost", immOut, 32'hFFFFFFF0);
  endtask

  task automatic testFlush;  // R7
    step(1, mk(OP_PRE, 5'd0, 5'd0, 16'h1357), 0, 0);
    step(0, 32'd0, 0, 1);
    chk("R7 outValid after flush", {31'd0, outValid}, 32'd0);
    step(1, mk(OP_IMMB, 5'd8, 5'd9, 16'h8001), 0, 0);
    chk("R7 prefix cleared", immOut, 32'hFFFF8001);
    step(1, mk(OP_IMMB, 5'd10, 5'd11, 16'h0002), 0, 1);
    chk("R7 word dropped valid", {31'd0, outValid}, 32'd0);
    chk("R7 word dropped imm", immOut, 32'hFFFF8001);
  endtask

  task automatic testStall;  // R8
    step(1, mk(OP_PRE, 5'd0, 5'd0, 16'h1234), 0, 0);
    step(1, mk(OP_IMMB, 5'd12, 5'd13, 16'h4444), 1, 0);
    chk("R8 imm held", immOut, 32'h00001234);
    chk("R8 isPrefix held", {31'd0, isPrefix}, 32'd1);
    chk("R8 rd held", {27'd0, rdIdx}, 32'd0);
    step(1, mk(OP_IMMB, 5'd12, 5'd13, 16'h5678), 0, 0);
    chk("R8 prefix survives", immOut, 32'h12345678);
    chk("R8 rd updates", {27'd0, rdIdx}, 32'd12);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testFields();
    testSignExt();
    testConcat();
    testLoss();
    testFlush();
    testStall();
    step(0, 32'd0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule